// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block gathers the interrupt causes of one serial UART channel into a single 8-bit status word and drives an active-low interrupt line from it. The causes are a change on the clear-to-send pin, the fill levels of the receive and transmit FIFOs compared against programmable thresholds, the transmitter's final-character indication, and three summary flags from secondary status registers. Those summary flags arrive already masked by their own enables.

Software reaches the block through a small register port. Address 0 holds the status word, which is cleared when it is read. Address 1 holds the interrupt enable mask. The interrupt line is low whenever a status bit and its enable bit are both set. Some causes are edge events that latch once. Others are level conditions that keep setting their bit while they hold. The transmit threshold bit also drops by itself when its condition goes away.

Top module: `uart_irq_agg`

## Requirements
- R1: After synchronous reset the status word is 0x60 (bit 6 receive-empty and bit 5 transmit-empty set, all others clear), the enable mask is 0x00 and irq_n is high.
- R2: Register address 0 is the status word and address 1 is the enable mask. A read returns data on reg_rdata in the cycle after reg_rd is sampled. A write to address 1 replaces the mask. A write to address 0 is ignored.
- R3: A read of address 0 clears every status bit. A bit whose set condition is present in the same cycle as the read stays set. Level-type bits (6, 5, 2, 1, 0) set again in every cycle their condition holds.
- R4: Bit 7 is set on any change of cts_in, rising or falling.
- R5: Bit 6 is set while rx_level equals 0. When rx_empty_inv is 1, it is set while rx_level is nonzero instead.
- R6: Bit 5 is set while tx_level equals 0 and tx_last_char is 1.
- R7: Bit 4 is set when the condition tx_level >= 8*trig_lvl[3:0] becomes true. It clears on the first cycle the condition is false, or on a status read.
- R8: Bit 3 is set when the condition (rx_level >= 8*trig_lvl[7:4]) XOR rx_trig_inv becomes true. Only a status read clears it.
- R9: Bits 2, 1 and 0 follow the level inputs sts_sum, spc_sum and lsr_sum respectively.
- R10: irq_n is low exactly when the status word ANDed with the enable mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_in | input | 1 | Clear-to-send pin, already synchronized |
| rx_level | input | 8 | Receive FIFO word count |
| tx_level | input | 8 | Transmit FIFO word count |
| trig_lvl | input | 8 | Threshold nibbles: [7:4] receive, [3:0] transmit, in units of 8 words |
| rx_empty_inv | input | 1 | Inverts the receive-empty condition |
| rx_trig_inv | input | 1 | Inverts the receive threshold condition |
| tx_last_char | input | 1 | Transmitter is shifting out its final character |
| sts_sum | input | 1 | Enabled secondary-status summary |
| spc_sum | input | 1 | Enabled special-character summary |
| lsr_sum | input | 1 | Enabled line-status error summary |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register address: 0 status, 1 enable |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after the read |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a new event. If the read-clear is not ordered behind the set, that event is lost without trace. The stimulus toggles cts_in on the same falling edge that raises reg_rd. The read must then return the old word, and the next read must show bit 7. The other hard cases are the transmit threshold bit dropping with no read after its level falls, and the receive threshold bit staying set after its level falls. Both are reached by moving the FIFO counts up and down across thresholds of 8 and 16 words.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt status aggregator.
// Assumes an 8-bit status word and a two-entry register map.
package uart_irq_pkg;
    localparam int ST_W = 8;

    // Status bit positions, most significant first
    localparam int B_CTS    = 7;
    localparam int B_RXEMP  = 6;
    localparam int B_TXEMP  = 5;
    localparam int B_TXTRG  = 4;
    localparam int B_RXTRG  = 3;
    localparam int B_STS    = 2;
    localparam int B_SPC    = 1;
    localparam int B_LSR    = 0;

    localparam logic [ST_W-1:0] ST_RESET = 8'h60;

    // Register addresses
    localparam int ADDR_STATUS = 0;
    localparam int ADDR_ENABLE = 1;
endpackage

// File: rtl/uart_irq_cond.sv
// Condition stage: turns the raw inputs into per-bit set requests and
// per-bit hold permissions for the status cells.
// Assumes all inputs are synchronous to clk; cts_in is pre-synchronized.
module uart_irq_cond
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int NIB_W      = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_in,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [2*NIB_W-1:0] trig_lvl,
    input  logic             rx_empty_inv,
    input  logic             rx_trig_inv,
    input  logic             tx_last_char,
    input  logic [2:0]       sum_in,
    output logic [ST_W-1:0]  set_vec,
    output logic [ST_W-1:0]  hold_ok
);
    localparam int STEP = FIFO_DEPTH >> NIB_W;
    localparam int N_THR = 2;   // index 0 transmit, 1 receive

    logic [LVL_W-1:0] thr [N_THR];
    logic             cts_prev;
    logic             txc_prev;
    logic             rxc_prev;
    logic             tx_cond;
    logic             rx_cond;

    // Threshold per FIFO: nibble scaled to words
    for (genvar k = 0; k < N_THR; k++) begin : g_thr
        assign thr[k] = LVL_W'(trig_lvl[k*NIB_W +: NIB_W]) * LVL_W'(STEP);
    end

    // Threshold comparisons, receive side optionally inverted
    always_comb begin
        tx_cond = (tx_level >= thr[0]);
        rx_cond = (rx_level >= thr[1]) ^ rx_trig_inv;
    end

    // History flops for the edge-sensitive sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cts_prev <= cts_in;
            txc_prev <= 1'b0;
            rxc_prev <= 1'b0;
        end else begin
            cts_prev <= cts_in;
            txc_prev <= tx_cond;
            rxc_prev <= rx_cond;
        end
    end

    // Set requests: edges for CTS and thresholds, levels elsewhere
    always_comb begin
        set_vec          = '0;
        set_vec[B_CTS]   = cts_in ^ cts_prev;
        set_vec[B_RXEMP] = (rx_level == '0) ^ rx_empty_inv;
        set_vec[B_TXEMP] = (tx_level == '0) & tx_last_char;
        set_vec[B_TXTRG] = tx_cond & ~txc_prev;
        set_vec[B_RXTRG] = rx_cond & ~rxc_prev;
        set_vec[B_STS]   = sum_in[2];
        set_vec[B_SPC]   = sum_in[1];
        set_vec[B_LSR]   = sum_in[0];
    end

    // Hold permission: only the transmit threshold bit self-clears
    always_comb begin
        hold_ok          = '1;
        hold_ok[B_TXTRG] = tx_cond;
    end
endmodule

// File: rtl/uart_irq_status.sv
// Status cells: one flop per bit, set wins over read-clear and self-clear.
// Assumes set and hold vectors are computed from the same cycle's inputs.
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter int                W        = ST_W,
    parameter logic [W-1:0]      RST_VAL  = ST_RESET
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] hold_ok,
    input  logic         rd_clr,
    output logic [W-1:0] status
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Per-bit sticky cell with priority set > clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status[i] <= RST_VAL[i];
            end else begin
                status[i] <= set_vec[i] | (status[i] & ~rd_clr & hold_ok[i]);
            end
        end
    end
endmodule

// File: rtl/uart_irq_regport.sv
// Register port: enable mask storage, registered read data, and the
// read-clear strobe for the status word.
// Assumes single-cycle strobes; read and write may coincide.
module uart_irq_regport
    import uart_irq_pkg::*;
#(
    parameter int W      = ST_W,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [W-1:0]      reg_wdata,
    input  logic [W-1:0]      status,
    output logic [W-1:0]      enable,
    output logic [W-1:0]      reg_rdata,
    output logic              rd_clr
);
    logic sel_stat;
    logic sel_en;

    // Address decode
    always_comb begin
        sel_stat = (reg_addr == ADDR_W'(ADDR_STATUS));
        sel_en   = (reg_addr == ADDR_W'(ADDR_ENABLE));
        rd_clr   = reg_rd & sel_stat;
    end

    // Enable mask register; status writes are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (reg_wr && sel_en) begin
            enable <= reg_wdata;
        end
    end

    // Read data capture, one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= sel_stat ? status : (sel_en ? enable : '0);
        end
    end
endmodule

// File: rtl/uart_irq_agg.sv
// Top of the UART interrupt status aggregator: condition stage, status
// cells, register port and the active-low interrupt output.
// Assumes one clock domain and a synchronous active-low reset.
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int NIB_W      = 4,
    parameter int ADDR_W     = 1,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cts_in,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic [2*NIB_W-1:0] trig_lvl,
    input  logic               rx_empty_inv,
    input  logic               rx_trig_inv,
    input  logic               tx_last_char,
    input  logic               sts_sum,
    input  logic               spc_sum,
    input  logic               lsr_sum,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [ST_W-1:0]    reg_wdata,
    output logic [ST_W-1:0]    reg_rdata,
    output logic               irq_n
);
    logic [ST_W-1:0] set_vec;
    logic [ST_W-1:0] hold_ok;
    logic [ST_W-1:0] stat_q;
    logic [ST_W-1:0] en_q;
    logic            rd_clr;

    uart_irq_cond #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .NIB_W      (NIB_W),
        .LVL_W      (LVL_W)
    ) u_cond (
        .clk          (clk),
        .rst_n        (rst_n),
        .cts_in       (cts_in),
        .rx_level     (rx_level),
        .tx_level     (tx_level),
        .trig_lvl     (trig_lvl),
        .rx_empty_inv (rx_empty_inv),
        .rx_trig_inv  (rx_trig_inv),
        .tx_last_char (tx_last_char),
        .sum_in       ({sts_sum, spc_sum, lsr_sum}),
        .set_vec      (set_vec),
        .hold_ok      (hold_ok)
    );

    uart_irq_status #(
        .W       (ST_W),
        .RST_VAL (ST_RESET)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .hold_ok (hold_ok),
        .rd_clr  (rd_clr),
        .status  (stat_q)
    );

    uart_irq_regport #(
        .W      (ST_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (stat_q),
        .enable    (en_q),
        .reg_rdata (reg_rdata),
        .rd_clr    (rd_clr)
    );

    // Interrupt line: low while any enabled status bit is set
    always_comb begin
        irq_n = ~|(stat_q & en_q);
    end
endmodule

// File: rtl/uart_irq_agg_chk.sv
// Checker for uart_irq_agg, attached with bind. Observes ports and the
// status and enable registers driven by separate submodules.
module uart_irq_agg_chk
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 128,
    parameter int NIB_W      = 4,
    parameter int ADDR_W     = 1,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cts_in,
    input logic [LVL_W-1:0]   tx_level,
    input logic [NIB_W-1:0]   tx_nib,
    input logic               reg_rd,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [ST_W-1:0]    reg_wdata,
    input logic [ST_W-1:0]    reg_rdata,
    input logic [ST_W-1:0]    stat_q,
    input logic [ST_W-1:0]    en_q
);
    localparam int STEP = FIFO_DEPTH >> NIB_W;
    logic [LVL_W-1:0] tx_thr;
    assign tx_thr = LVL_W'(tx_nib) * LVL_W'(STEP);

    AST_CTS_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_in != $past(cts_in)) |=> stat_q[B_CTS]); // R4

    AST_READ_CLEARS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(ADDR_STATUS) && cts_in == $past(cts_in))
        |=> !stat_q[B_CTS]); // R3

    AST_TXTRIG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level < tx_thr) |=> !stat_q[B_TXTRG]); // R7

    AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(ADDR_ENABLE)) |=> (en_q == $past(reg_wdata))); // R2

    AST_STATUS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(ADDR_STATUS)) |=> (reg_rdata == $past(stat_q))); // R2
endmodule

bind uart_irq_agg uart_irq_agg_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .NIB_W      (NIB_W),
    .ADDR_W     (ADDR_W),
    .LVL_W      (LVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts_in    (cts_in),
    .tx_level  (tx_level),
    .tx_nib    (trig_lvl[NIB_W-1:0]),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .stat_q    (stat_q),
    .en_q      (en_q)
);

// File: tb/tb_uart_irq_agg.sv
// Scoreboard bench: read tasks queue expected words, a monitor pops and
// compares them when the read data appears.
module tb_uart_irq_agg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_in = 1'b0;
    logic [7:0] rx_level = 8'd0;
    logic [7:0] tx_level = 8'd0;
    logic [7:0] trig_lvl = 8'h21;   // rx threshold 16, tx threshold 8
    logic       rx_empty_inv = 1'b0;
    logic       rx_trig_inv = 1'b0;
    logic       tx_last_char = 1'b0;
    logic       sts_sum = 1'b0;
    logic       spc_sum = 1'b0;
    logic       lsr_sum = 1'b0;
    logic       reg_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [0:0] reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_seen = 1'b0;

    always #4 clk = ~clk;

    uart_irq_agg dut (
        .clk(clk), .rst_n(rst_n), .cts_in(cts_in), .rx_level(rx_level),
        .tx_level(tx_level), .trig_lvl(trig_lvl), .rx_empty_inv(rx_empty_inv),
        .rx_trig_inv(rx_trig_inv), .tx_last_char(tx_last_char),
        .sts_sum(sts_sum), .spc_sum(spc_sum), .lsr_sum(lsr_sum),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: note each sampled read, compare data half a cycle later
    always @(posedge clk) rd_seen <= reg_rd & rst_n;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R2 unexpected read data actual=%h expected=none", reg_rdata);
            end else begin
                check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic rd_reg(input logic a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        reg_addr = a;
        reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'd1);
        rx_level = 8'd5;
        rd_reg(1'b1, 8'h00, "R1 enable reset value");
        rd_reg(1'b0, 8'h60, "R1 status reset value");
        rd_reg(1'b0, 8'h00, "R3 read cleared all bits");

        wr_reg(1'b1, 8'hFF);
        rd_reg(1'b1, 8'hFF, "R2 enable readback");
        check("R10 irq_n idle with mask set", {7'd0, irq_n}, 8'd1);
        wr_reg(1'b0, 8'hFF);
        rd_reg(1'b0, 8'h00, "R2 status write ignored");

        cts_in = 1'b1;
        @(negedge clk);
        check("R10 irq_n low on enabled bit", {7'd0, irq_n}, 8'd0);
        rd_reg(1'b0, 8'h80, "R4 rising cts");
        check("R3 irq_n released by read", {7'd0, irq_n}, 8'd1);
        rd_reg(1'b0, 8'h00, "R3 cts bit cleared");
        cts_in = 1'b0;
        @(negedge clk);
        rd_reg(1'b0, 8'h80, "R4 falling cts");

        wr_reg(1'b1, 8'h7F);
        cts_in = 1'b1;
        @(negedge clk);
        check("R10 masked bit keeps irq_n high", {7'd0, irq_n}, 8'd1);
        rd_reg(1'b0, 8'h80, "R4 masked cts still recorded");
        wr_reg(1'b1, 8'hFF);

        rx_empty_inv = 1'b1;
        @(negedge clk);
        rx_empty_inv = 1'b0;
        rd_reg(1'b0, 8'h40, "R5 inverted empty flags non-empty");
        rd_reg(1'b0, 8'h00, "R5 inverted sense off");
        rx_level = 8'd0;
        @(negedge clk);
        rd_reg(1'b0, 8'h40, "R5 empty receive fifo");
        rx_level = 8'd5;
        rd_reg(1'b0, 8'h40, "R3 level bit set again after read");
        rd_reg(1'b0, 8'h00, "R5 bit gone once fifo non-empty");

        tx_last_char = 1'b1;
        @(negedge clk);
        rd_reg(1'b0, 8'h20, "R6 tx empty on last char");
        tx_last_char = 1'b0;
        rd_reg(1'b0, 8'h20, "R6 re-set while condition held");
        rd_reg(1'b0, 8'h00, "R6 cleared without last char");

        tx_level = 8'd8;
        @(negedge clk);
        rd_reg(1'b0, 8'h10, "R7 tx threshold reached at 8");
        rd_reg(1'b0, 8'h00, "R7 read clears while above");
        tx_level = 8'd3;
        @(negedge clk);
        tx_level = 8'd9;
        @(negedge clk);
        check("R10 irq_n low on tx trigger", {7'd0, irq_n}, 8'd0);
        tx_level = 8'd4;
        @(negedge clk);
        check("R7 irq_n high after self-clear", {7'd0, irq_n}, 8'd1);
        rd_reg(1'b0, 8'h00, "R7 self-cleared below threshold");
        tx_level = 8'd7;
        @(negedge clk);
        rd_reg(1'b0, 8'h00, "R7 level 7 below threshold");
        tx_level = 8'd0;
        @(negedge clk);

        rx_level = 8'd15;
        @(negedge clk);
        rd_reg(1'b0, 8'h00, "R8 level 15 below threshold");
        rx_level = 8'd16;
        @(negedge clk);
        rx_level = 8'd5;
        idle(2);
        rd_reg(1'b0, 8'h08, "R8 held after level fell");
        rd_reg(1'b0, 8'h00, "R8 cleared by read");
        rx_trig_inv = 1'b1;
        @(negedge clk);
        rd_reg(1'b0, 8'h08, "R8 inverted meaning");
        rx_trig_inv = 1'b0;
        @(negedge clk);
        rd_reg(1'b0, 8'h00, "R8 idle after inversion off");

        sts_sum = 1'b1;
        @(negedge clk);
        sts_sum = 1'b0;
        rd_reg(1'b0, 8'h04, "R9 secondary status summary");
        spc_sum = 1'b1;
        lsr_sum = 1'b1;
        @(negedge clk);
        spc_sum = 1'b0;
        lsr_sum = 1'b0;
        rd_reg(1'b0, 8'h03, "R9 special and line-status summaries");
        rd_reg(1'b0, 8'h00, "R9 summaries cleared");

        // Event in the same cycle as the read: set must win
        exp_q.push_back(8'h00);
        tag_q.push_back("R3 read coinciding with cts change");
        reg_addr = 1'b0;
        reg_rd = 1'b1;
        cts_in = 1'b0;
        @(negedge clk);
        reg_rd = 1'b0;
        @(negedge clk);
        rd_reg(1'b0, 8'h80, "R3 coinciding event kept");

        idle(2);
        check("R2 all queued reads consumed", 8'(exp_q.size()), 8'd0);
        finish_run();
    end
endmodule